// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block holds the program counter of a 32-bit processor and works out the address of the next instruction. Each cycle it takes an operation code that has already been decoded, the 16-bit immediate, the 26-bit jump field, the destination register index and the values of two source registers. From these it produces the next PC. Instructions are 32 bits wide and word-aligned, so straight-line code steps by 4.

A branch can compare its two registers for equality or inequality. It can also test the first register, read as signed, against zero. A taken branch lands at a PC-relative target scaled to words. An absolute jump keeps the top four bits of the current PC and appends the word-scaled 26-bit field. A register jump takes its target from the first register. The linking forms also give the return address, the index of the register that receives it, and a write strobe for that register.

The PC register loads the computed address on each clock edge where the advance input is high. A register jump whose target is not word-aligned raises a fault flag. While the fault is raised, the PC does not load.

Top module: `npc_unit`

## Requirements
- R1: After the asynchronous active-low reset, pc_o equals the RESET_PC parameter (default 32'h0040_0000). pc_o keeps its value across any clock edge where advance_i is low.
- R2: op_i codes 0 (sequential) and 11 to 15 (unused) give next_pc_o = pc_o + 4 and taken_o = 0.
- R3: Code 1 takes the branch when rs_val_i == rt_val_i. Code 2 takes it when the two differ. A taken branch gives next_pc_o = pc_o + 4 + 4*sext(imm_i) and taken_o = 1. A branch that is not taken gives pc_o + 4 and taken_o = 0.
- R4: The zero tests read rs_val_i as signed. Code 3 takes the branch when the value is < 0, code 4 when <= 0, code 5 when > 0 and code 6 when >= 0. Targets are formed as in R3.
- R5: The immediate spans -2^15 to 2^15-1 words. imm_i = 16'h7FFF adds 131068 bytes to pc_o + 4, and imm_i = 16'h8000 subtracts 131072 bytes. The sum wraps modulo 2^32.
- R6: Code 7 (jump) and code 8 (jump and link) give next_pc_o = {pc_o[31:28], target_i, 2'b00} and taken_o = 1.
- R7: Code 9 (register jump) and code 10 (register jump and link) give next_pc_o = rs_val_i and taken_o = 1 when rs_val_i[1:0] == 0.
- R8: link_data_o is always pc_o + 4. link_we_o is 1 only for code 8, with link_idx_o = 31, and for an aligned code 10, with link_idx_o = rd_i.
- R9: For code 9 or 10 with rs_val_i[1:0] != 0, align_fault_o = 1, taken_o = 0 and link_we_o = 0. pc_o does not change at the next edge, even when advance_i is high.
- R10: On a rising edge where advance_i = 1 and align_fault_o = 0, pc_o takes the value next_pc_o had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| advance_i | input | 1 | Load the PC at this edge |
| op_i | input | 4 | Decoded control-flow operation |
| imm_i | input | 16 | Signed branch offset, in words |
| target_i | input | 26 | Jump field, in words |
| rd_i | input | 5 | Link register index for the register jump with link |
| rs_val_i | input | 32 | First source operand |
| rt_val_i | input | 32 | Second source operand |
| pc_o | output | 32 | Current PC |
| next_pc_o | output | 32 | Computed next PC |
| taken_o | output | 1 | Control flow leaves the sequential path |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_data_o | output | 32 | Return address |
| align_fault_o | output | 1 | Register jump target is misaligned |

## Verification
The outputs next_pc_o, taken_o, the link outputs and align_fault_o are combinational in the current pc_o and the inputs, so they are due in the same cycle as the stimulus. pc_o moves only at the following rising edge. The driver applies each stimulus at the falling edge, and the monitor compares the combinational results a quarter period later, before the edge that consumes them. The PC is checked one item later, against a model PC that the driver advances only when advance is high and no fault is raised.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    OP_SEQ  = 4'd0,
    OP_BEQ  = 4'd1,
    OP_BNE  = 4'd2,
    OP_BLTZ = 4'd3,
    OP_BLEZ = 4'd4,
    OP_BGTZ = 4'd5,
    OP_BGEZ = 4'd6,
    OP_J    = 4'd7,
    OP_JAL  = 4'd8,
    OP_JR   = 4'd9,
    OP_JALR = 4'd10
  } npc_op_e;

  localparam int unsigned OP_W = 4;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            take_o
);
  logic eq, neg, zero;

  assign eq   = (a_i == b_i);
  assign neg  = a_i[XLEN-1];
  assign zero = (a_i == '0);

  always_comb begin
    take_o = 1'b0;
    case (op_i)
      OP_BEQ:  take_o = eq;
      OP_BNE:  take_o = !eq;
      OP_BLTZ: take_o = neg;
      OP_BLEZ: take_o = neg || zero;
      OP_BGTZ: take_o = !neg && !zero;
      OP_BGEZ: take_o = !neg;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned TGT_W = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  br_o,
  output logic [XLEN-1:0]  jmp_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W - 2;
  localparam int unsigned HI_W  = XLEN - TGT_W - 2;

  logic [XLEN-1:0] br_off;

  // word offset, sign-extended and scaled by 4
  assign br_off = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign seq_o  = pc_i + XLEN'(4);
  assign br_o   = seq_o + br_off;
  assign jmp_o  = {pc_i[XLEN-1 -: HI_W], tgt_i, 2'b00};
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RESET_PC;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     IMM_W    = 16,
  parameter int unsigned     TGT_W    = 26,
  parameter int unsigned     RIDX_W   = 5,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic [RIDX_W-1:0] rd_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_data_o,
  output logic              align_fault_o
);
  localparam logic [RIDX_W-1:0] LINK_REG = '1;

  logic [XLEN-1:0] pc_q, seq_pc, br_pc, jmp_pc;
  logic            br_take, mis;

  npc_cond #(.XLEN(XLEN)) i_cond (
    .op_i  (op_i),
    .a_i   (rs_val_i),
    .b_i   (rt_val_i),
    .take_o(br_take)
  );

  npc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W)) i_tgt (
    .pc_i (pc_q),
    .imm_i(imm_i),
    .tgt_i(target_i),
    .seq_o(seq_pc),
    .br_o (br_pc),
    .jmp_o(jmp_pc)
  );

  assign mis = (rs_val_i[1:0] != 2'b00);

  always_comb begin
    next_pc_o     = seq_pc;
    taken_o       = 1'b0;
    link_we_o     = 1'b0;
    link_idx_o    = rd_i;
    align_fault_o = 1'b0;
    case (op_i)
      OP_BEQ, OP_BNE, OP_BLTZ, OP_BLEZ, OP_BGTZ, OP_BGEZ: begin
        if (br_take) begin
          next_pc_o = br_pc;
          taken_o   = 1'b1;
        end
      end
      OP_J: begin
        next_pc_o = jmp_pc;
        taken_o   = 1'b1;
      end
      OP_JAL: begin
        next_pc_o  = jmp_pc;
        taken_o    = 1'b1;
        link_we_o  = 1'b1;
        link_idx_o = LINK_REG;
      end
      OP_JR, OP_JALR: begin
        if (mis) begin
          align_fault_o = 1'b1;
        end else begin
          next_pc_o = rs_val_i;
          taken_o   = 1'b1;
          link_we_o = (op_i == OP_JALR);
        end
      end
      default: ;
    endcase
  end

  assign link_data_o = seq_pc;

  npc_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) i_pc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(advance_i && !align_fault_o),
    .d_i   (next_pc_o),
    .q_o   (pc_q)
  );

  assign pc_o = pc_q;
endmodule

// File: rtl/npc_checks.sv
module npc_checks
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            advance_i,
  input logic [OP_W-1:0] op_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic            align_fault_o
);
  a_r1_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |=> $stable(pc_o));

  a_r10_load_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !align_fault_o) |=> (pc_o == $past(next_pc_o)));

  a_r9_fault_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fault_o |=> $stable(pc_o));

  a_r9_fault_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fault_o |-> (!link_we_o && !taken_o));

  a_r8_link_only_jal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (op_i == OP_JAL || op_i == OP_JALR));

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SEQ) |-> (next_pc_o == pc_o + XLEN'(4) && !taken_o));
endmodule

bind npc_unit npc_checks #(.XLEN(XLEN)) i_npc_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .advance_i    (advance_i),
  .op_i         (op_i),
  .pc_o         (pc_o),
  .next_pc_o    (next_pc_o),
  .taken_o      (taken_o),
  .link_we_o    (link_we_o),
  .align_fault_o(align_fault_o)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
  localparam int CLK_P = 10;
  localparam logic [31:0] RST_PC = 32'h0040_0000;

  logic        clk_i = 1'b0, rst_ni = 1'b0, advance_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [15:0] imm_i = '0;
  logic [25:0] target_i = '0;
  logic [4:0]  rd_i = '0;
  logic [31:0] rs_val_i = '0, rt_val_i = '0;
  logic [31:0] pc_o, next_pc_o, link_data_o;
  logic        taken_o, link_we_o, align_fault_o;
  logic [4:0]  link_idx_o;

  npc_unit i_npc_unit (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  typedef struct {
    string       tag;
    logic [31:0] pc, nxt, ldata;
    logic        tk, lwe, flt;
    logic [4:0]  lidx;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] model_pc;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(string tag, logic adv, logic [3:0] op, logic [31:0] rs,
                       logic [31:0] rt, logic [15:0] imm, logic [25:0] tgt, logic [4:0] rd);
    item_t it;
    logic [31:0] seq, br;
    logic cond;
    @(negedge clk_i);
    advance_i = adv; op_i = op; rs_val_i = rs; rt_val_i = rt;
    imm_i = imm; target_i = tgt; rd_i = rd;
    seq = model_pc + 32'd4;
    br  = seq + {{14{imm[15]}}, imm, 2'b00};
    it.tag = tag; it.pc = model_pc; it.nxt = seq; it.tk = 0;
    it.lwe = 0; it.lidx = 0; it.ldata = seq; it.flt = 0;
    cond = 0;
    case (op)
      4'd1: cond = (rs == rt);
      4'd2: cond = (rs != rt);
      4'd3: cond = $signed(rs) < 0;
      4'd4: cond = $signed(rs) <= 0;
      4'd5: cond = $signed(rs) > 0;
      4'd6: cond = $signed(rs) >= 0;
      default: cond = 0;
    endcase
    if (cond) begin it.nxt = br; it.tk = 1; end
    if (op == 4'd7 || op == 4'd8) begin
      it.nxt = {model_pc[31:28], tgt, 2'b00}; it.tk = 1;
      if (op == 4'd8) begin it.lwe = 1; it.lidx = 5'd31; end
    end
    if (op == 4'd9 || op == 4'd10) begin
      if (rs[1:0] != 2'b00) it.flt = 1;
      else begin
        it.nxt = rs; it.tk = 1;
        if (op == 4'd10) begin it.lwe = 1; it.lidx = rd; end
      end
    end
    q.push_back(it);
    if (adv && !it.flt) model_pc = it.nxt;
  endtask

  // monitor: combinational results before the consuming edge
  initial begin
    forever begin
      @(negedge clk_i);
      #(CLK_P/4);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, "pc (R10)", pc_o, it.pc);
        chk(it.tag, "next_pc", next_pc_o, it.nxt);
        chk(it.tag, "taken", 32'(taken_o), 32'(it.tk));
        chk(it.tag, "link_we (R8)", 32'(link_we_o), 32'(it.lwe));
        chk(it.tag, "fault (R9)", 32'(align_fault_o), 32'(it.flt));
        chk(it.tag, "link_data (R8)", link_data_o, it.ldata);
        if (it.lwe) chk(it.tag, "link_idx (R8)", 32'(link_idx_o), 32'(it.lidx));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 2000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    model_pc = RST_PC;
    #(CLK_P * 2 + 1);
    chk("R1", "reset pc", pc_o, RST_PC);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 sequential and unused codes
    apply("R2 seq", 1, 4'd0, 0, 0, 16'h0010, 0, 0);
    apply("R2 unused", 1, 4'd13, 5, 5, 16'h0010, 0, 0);
    // R3 register compares
    apply("R3 beq taken", 1, 4'd1, 32'h1234, 32'h1234, 16'h0004, 0, 0);
    apply("R3 beq not", 1, 4'd1, 32'h1234, 32'h1235, 16'h0004, 0, 0);
    apply("R3 bne taken back", 1, 4'd2, 1, 2, 16'hFFFD, 0, 0);
    apply("R3 bne not", 1, 4'd2, 7, 7, 16'h0020, 0, 0);
    // R4 zero tests
    apply("R4 bltz neg", 1, 4'd3, 32'h8000_0000, 0, 16'h0002, 0, 0);
    apply("R4 bltz zero", 1, 4'd3, 0, 0, 16'h0002, 0, 0);
    apply("R4 blez zero", 1, 4'd4, 0, 0, 16'h0003, 0, 0);
    apply("R4 blez pos", 1, 4'd4, 1, 0, 16'h0003, 0, 0);
    apply("R4 bgtz pos", 1, 4'd5, 32'h7FFF_FFFF, 0, 16'h0005, 0, 0);
    apply("R4 bgtz zero", 1, 4'd5, 0, 0, 16'h0005, 0, 0);
    apply("R4 bgez zero", 1, 4'd6, 0, 0, 16'h0001, 0, 0);
    apply("R4 bgez neg", 1, 4'd6, 32'hFFFF_FFFF, 0, 16'h0001, 0, 0);
    // R5 reach limits
    apply("R5 max fwd", 1, 4'd1, 0, 0, 16'h7FFF, 0, 0);
    apply("R5 max back", 1, 4'd1, 0, 0, 16'h8000, 0, 0);
    // R6 absolute jumps, R8 link
    apply("R6 jump", 1, 4'd7, 0, 0, 0, 26'h3AB_CDEF, 0);
    apply("R8 jal", 1, 4'd8, 0, 0, 0, 26'h000_0100, 5'd3);
    // R7 register jumps
    apply("R7 jr", 1, 4'd9, 32'hA000_0040, 0, 0, 0, 0);
    apply("R8 jalr", 1, 4'd10, 32'h0040_1000, 0, 0, 0, 5'd7);
    // R9 misaligned, advance high: pc must hold
    apply("R9 jr mis", 1, 4'd9, 32'h0040_2002, 0, 0, 0, 0);
    apply("R9 jalr mis", 1, 4'd10, 32'h0040_2001, 0, 0, 0, 5'd9);
    // R1 idle: pc holds with advance low
    apply("R1 idle", 0, 4'd7, 0, 0, 0, 26'h155_5555, 0);
    apply("R10 after idle", 1, 4'd0, 0, 0, 0, 0, 0);
    @(negedge clk_i);
    advance_i = 1'b0;
    #(CLK_P/4);
    chk("R10", "final pc", pc_o, model_pc);
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule